// File: doc/BRIEF.md
# Thermal printhead shift-latch driver

This block is the digital core of a 64-dot thermal print head driver. Dot data for one print line arrives one bit at a time. Each bit is taken when the shift strobe is high at a rising edge of the core clock, and it moves through a 64-stage shift register. The last stage is presented on a serial output, so several devices can be chained into one long line.

A 64-bit line latch sits between the shift register and the dot outputs. It is transparent while the latch input and the latch polarity input are at the same level, and it holds while they differ. The latched bits reach the dot-on outputs only when the active-low enable is low, the active-high enable is high and no supply-low indication is present.

An optional history mode replaces each incoming bit with "new AND NOT old", using a second serial input that carries the previous line. This lets a dot that is already hot skip its preheat pulse. The analog driver transistors, pull resistors and voltage detector are outside this block. The supply-low flag and the default tie levels of the unused pins stand in for them.

Top module: `tph_driver`

## Requirements
- R1: After the asynchronous active-low reset, every shift stage and every latch bit is 0, so the serial output is 0 and, once the outputs are enabled with the latch transparent, every dot output is 0.
- R2: At a clock edge where the shift strobe is high, stage 0 takes the incoming bit and stage k takes stage k-1. At an edge where the strobe is low, the register holds. The serial output always shows stage 63.
- R3: While history mode is high, the incoming bit is the serial data input ANDed with the inverse of the old-data input. While history mode is low, the old-data input has no effect.
- R4: While the latch input equals the latch polarity input (both 0, or both 1), the latch is transparent and the dot outputs follow the shift stages with no added clock delay.
- R5: While the latch input differs from the polarity input, the latch holds its contents, and further shifting does not change the dot outputs. A latch pulse that lasts at least one clock cycle captures the current stages.
- R6: Dot output n is 1 only when the active-low enable is 0, the active-high enable is 1 and latch bit n is 1. Either enable in its off state forces all 64 outputs to 0. With the default tie levels (active-low enable 1, active-high enable 0) the outputs are off.
- R7: While the supply-low flag is 1, all dot outputs are 0 whatever the other inputs are.
- R8: When the serial output of one device feeds the serial input of a second device, the two behave as one 128-stage register. After 128 shifts, the first 64 bits shifted in sit in the second device.
- R9: Latch bit n drives dot output n. The first of 64 consecutive shifted bits ends in stage 63 (dot 63), and the last ends in stage 0 (dot 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shift_i | input | 1 | Shift strobe, one stage per edge while high |
| sdi_i | input | 1 | Serial dot data in |
| old_i | input | 1 | Previous-line serial data |
| hist_en_i | input | 1 | History mode select |
| ld_i | input | 1 | Latch control level |
| ld_pol_i | input | 1 | Level of ld_i that makes the latch transparent |
| en_n_i | input | 1 | Active-low output enable |
| en_i | input | 1 | Active-high output enable |
| vlow_i | input | 1 | Supply-low flag, forces outputs off |
| sdo_o | output | 1 | Serial out, last shift stage |
| dot_on_o | output | 64 | Per-dot driver-on outputs |

## Verification
The hard case is a latch that is closed while a new line is shifted in and then opens for a single cycle, with the clock still running. To reach it, the bench closes the latch, shifts in a complete new line and checks that the outputs still show the old one. It then opens and closes the latch within one cycle and compares the outputs against the register contents modelled in the bench. A cascade case drives 128 bits through two chained instances and checks the serial output of the second instance after every shift. Checking it after every shift exposes any off-by-one error at the boundary between the devices.

// File: rtl/tph_pkg.sv
package tph_pkg;
  localparam int unsigned DOTS_DEF = 64;

  function automatic logic hist_mix(input logic nw, input logic old, input logic en);
    return en ? (nw & ~old) : nw;
  endfunction
endpackage

// File: rtl/tph_shift.sv
module tph_shift #(
  parameter int unsigned DOTS = tph_pkg::DOTS_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            din_i,
  output logic [DOTS-1:0] q_o,
  output logic [DOTS-1:0] d_o
);
  logic [DOTS-1:0] q;

  always_comb d_o = shift_i ? {q[DOTS-2:0], din_i} : q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= d_o;

  assign q_o = q;
endmodule

// File: rtl/tph_latch.sv
module tph_latch #(
  parameter int unsigned DOTS = tph_pkg::DOTS_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            open_i,
  input  logic [DOTS-1:0] sr_q_i,
  input  logic [DOTS-1:0] sr_d_i,
  output logic [DOTS-1:0] lat_o
);
  logic [DOTS-1:0] held;

  // load next register value so held matches sr_q when the latch closes
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     held <= '0;
    else if (open_i) held <= sr_d_i;

  assign lat_o = open_i ? sr_q_i : held;
endmodule

// File: rtl/tph_gate.sv
module tph_gate #(
  parameter int unsigned DOTS = tph_pkg::DOTS_DEF
) (
  input  logic            en_n_i,
  input  logic            en_i,
  input  logic            vlow_i,
  input  logic [DOTS-1:0] lat_i,
  output logic [DOTS-1:0] dot_o
);
  logic drive_ok;
  assign drive_ok = ~en_n_i & en_i & ~vlow_i;

  for (genvar i = 0; i < DOTS; i++) begin : g_dot
    assign dot_o[i] = lat_i[i] & drive_ok;
  end
endmodule

// File: rtl/tph_driver.sv
module tph_driver #(
  parameter int unsigned DOTS = tph_pkg::DOTS_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            sdi_i,
  input  logic            old_i,
  input  logic            hist_en_i,
  input  logic            ld_i,
  input  logic            ld_pol_i,
  input  logic            en_n_i,
  input  logic            en_i,
  input  logic            vlow_i,
  output logic            sdo_o,
  output logic [DOTS-1:0] dot_on_o
);
  logic            din;
  logic            lat_open;
  logic [DOTS-1:0] sr_q;
  logic [DOTS-1:0] sr_d;
  logic [DOTS-1:0] lat_q;

  assign din      = tph_pkg::hist_mix(sdi_i, old_i, hist_en_i);
  assign lat_open = (ld_i == ld_pol_i);

  tph_shift #(.DOTS(DOTS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_i),
    .din_i  (din),
    .q_o    (sr_q),
    .d_o    (sr_d)
  );

  tph_latch #(.DOTS(DOTS)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (lat_open),
    .sr_q_i (sr_q),
    .sr_d_i (sr_d),
    .lat_o  (lat_q)
  );

  tph_gate #(.DOTS(DOTS)) u_gate (
    .en_n_i (en_n_i),
    .en_i   (en_i),
    .vlow_i (vlow_i),
    .lat_i  (lat_q),
    .dot_o  (dot_on_o)
  );

  assign sdo_o = sr_q[DOTS-1];
endmodule

// File: rtl/tph_driver_chk.sv
module tph_driver_chk #(
  parameter int unsigned DOTS = tph_pkg::DOTS_DEF
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            shift_i,
  input logic            sdi_i,
  input logic            old_i,
  input logic            hist_en_i,
  input logic            ld_i,
  input logic            ld_pol_i,
  input logic            en_n_i,
  input logic            en_i,
  input logic            vlow_i,
  input logic            sdo_o,
  input logic [DOTS-1:0] dot_on_o,
  input logic [DOTS-1:0] stage_i,
  input logic [DOTS-1:0] lat_i
);
  // R2
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> stage_i[DOTS-1:1] == $past(stage_i[DOTS-2:0]));

  // R2
  shift_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(stage_i) && $stable(sdo_o));

  // R3
  hist_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && hist_en_i) |=> stage_i[0] == $past(sdi_i & ~old_i));

  // R3
  hist_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !hist_en_i) |=> stage_i[0] == $past(sdi_i));

  // R4
  lat_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i == ld_pol_i) |-> lat_i == stage_i);

  // R5
  lat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i != ld_pol_i) |=> (ld_i == ld_pol_i) || $stable(lat_i));

  // R6
  drive_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_n_i || !en_i) |-> dot_on_o == '0);

  // R7
  vlow_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vlow_i |-> dot_on_o == '0);

  // R6
  drive_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_n_i && en_i && !vlow_i) |-> dot_on_o == lat_i);
endmodule

bind tph_driver tph_driver_chk #(.DOTS(DOTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .shift_i  (shift_i),
  .sdi_i    (sdi_i),
  .old_i    (old_i),
  .hist_en_i(hist_en_i),
  .ld_i     (ld_i),
  .ld_pol_i (ld_pol_i),
  .en_n_i   (en_n_i),
  .en_i     (en_i),
  .vlow_i   (vlow_i),
  .sdo_o    (sdo_o),
  .dot_on_o (dot_on_o),
  .stage_i  (sr_q),
  .lat_i    (lat_q)
);

// File: tb/tb_tph_driver.sv
module tb_tph_driver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift = 1'b0, sdi = 1'b0, old = 1'b0, hist = 1'b0;
  logic ld = 1'b0, pol = 1'b0, en_n = 1'b1, en = 1'b0, vlow = 1'b0;
  logic sdo_a, sdo_b;
  logic [63:0] dot_a, dot_b;
  logic [63:0] m_a = '0, m_b = '0, l_a = '0, l_b = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [63:0] QW1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] QW2 = 64'hDEAD_BEEF_5A5A_C3C3;

  always #4 clk = ~clk;

  tph_driver dut (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .sdi_i(sdi), .old_i(old),
    .hist_en_i(hist), .ld_i(ld), .ld_pol_i(pol), .en_n_i(en_n), .en_i(en),
    .vlow_i(vlow), .sdo_o(sdo_a), .dot_on_o(dot_a)
  );

  tph_driver dut_b (
    .clk_i(clk), .rst_ni(rst_n), .shift_i(shift), .sdi_i(sdo_a), .old_i(1'b0),
    .hist_en_i(1'b0), .ld_i(ld), .ld_pol_i(pol), .en_n_i(en_n), .en_i(en),
    .vlow_i(vlow), .sdo_o(sdo_b), .dot_on_o(dot_b)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_dot(input logic [63:0] lat);
    return (!en_n && en && !vlow) ? lat : 64'h0;
  endfunction

  task automatic sync_lat();
    if (ld == pol) begin l_a = m_a; l_b = m_b; end
  endtask

  task automatic check_all(input string req);
    #1;
    chk({req, " dot_a"}, dot_a, exp_dot(l_a));
    chk({req, " dot_b"}, dot_b, exp_dot(l_b));
    chk({req, " sdo_a"}, {63'h0, sdo_a}, {63'h0, m_a[63]});
    chk({req, " sdo_b"}, {63'h0, sdo_b}, {63'h0, m_b[63]});
  endtask

  task automatic shift1(input logic d, input logic o);
    logic nb;
    @(negedge clk); sdi = d; old = o; shift = 1'b1;
    @(negedge clk); shift = 1'b0;
    nb = hist ? (d & ~o) : d;
    m_b = {m_b[62:0], m_a[63]};
    m_a = {m_a[62:0], nb};
    sync_lat();
  endtask

  task automatic set_ctl(input logic l, input logic p);
    @(negedge clk); ld = l; pol = p;
    sync_lat();
  endtask

  task automatic set_en(input logic an, input logic a, input logic v);
    @(negedge clk); en_n = an; en = a; vlow = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state seen through enabled, transparent outputs
    set_en(1'b0, 1'b1, 1'b0);
    check_all("R1");
    chk("R1 dot_a zero", dot_a, 64'h0);
    // R6 default tie levels keep outputs off
    set_en(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) shift1(1'b1, 1'b0);
    #1 chk("R6 default off", dot_a, 64'h0);
    set_en(1'b0, 1'b1, 1'b0);
    #1 chk("R4 open follows", dot_a, 64'hFF);
    // R9 mapping: first bit lands on dot 63
    for (int i = 63; i >= 0; i--) shift1(PAT[i], 1'b0);
    #1 chk("R9 mapping", dot_a, PAT);
    chk("R8 spill to b", dot_b, 64'hFF);
    check_all("R2");
    // R5 hold while levels differ
    set_ctl(1'b1, 1'b0);
    for (int i = 63; i >= 0; i--) shift1(~PAT[i], 1'b0);
    #1 chk("R5 hold", dot_a, PAT);
    check_all("R5");
    // R4 transparent with polarity 1
    set_ctl(1'b1, 1'b1);
    #1 chk("R4 pol1 open", dot_a, ~PAT);
    set_ctl(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) shift1(1'b0, 1'b0);
    #1 chk("R5 pol1 hold", dot_a, ~PAT);
    // R5 one-cycle latch pulse
    set_ctl(1'b1, 1'b1);
    set_ctl(1'b0, 1'b1);
    #1 chk("R5 pulse capture", dot_a, {~PAT[47:0], 16'h0});
    check_all("R5 pulse");
    // R6 R7 enable sweep
    for (int k = 0; k < 8; k++) begin
      set_en(k[0], k[1], k[2]);
      #1 chk("R6 R7 sweep", dot_a,
             (!k[0] && k[1] && !k[2]) ? {~PAT[47:0], 16'h0} : 64'h0);
      check_all("R7");
    end
    set_en(1'b0, 1'b1, 1'b0);
    set_ctl(1'b0, 1'b0);
    // R3 history combinations
    @(negedge clk); hist = 1'b1;
    for (int k = 0; k < 4; k++) begin
      shift1(k[1], k[0]);
      #1 chk("R3 hist on", {63'h0, dot_a[0]}, {63'h0, k[1] & ~k[0]});
    end
    @(negedge clk); hist = 1'b0;
    shift1(1'b1, 1'b1);
    #1 chk("R3 hist off ignores old", {63'h0, dot_a[0]}, 64'h1);
    check_all("R3");
    // R8 cascade 128 bits
    for (int i = 63; i >= 0; i--) begin
      shift1(QW1[i], 1'b0);
      #1 chk("R8 sdo_b", {63'h0, sdo_b}, {63'h0, m_b[63]});
    end
    for (int i = 63; i >= 0; i--) begin
      shift1(QW2[i], 1'b0);
      #1 chk("R8 sdo_b", {63'h0, sdo_b}, {63'h0, m_b[63]});
    end
    #1 chk("R8 dev b", dot_b, QW1);
    chk("R8 dev a", dot_a, QW2);
    // R2 idle cycles hold
    repeat (5) @(negedge clk);
    check_all("R2 idle");
    chk("R2 idle a", dot_a, QW2);
    finish_run();
  end
endmodule